// File: doc/BRIEF.md
# Lockable Translation Lookaside Buffer

This block sits between a requester and memory. It turns the virtual page number of each request into a physical page number and checks whether the requester may touch that page. The block keeps a small fully associative set of recently used page-table entries. A request whose page is held completes one cycle after it is accepted. A request whose page is not held starts a single-level table walk over a valid/ready read port. The fetched entry is then installed and the translation completes one cycle after the walk response arrives.

Any entry can be locked, so a critical mapping stays resident and is never chosen as a replacement victim. When every entry is locked, a refill is still used to answer the request but is not kept. A protection-only mode leaves the address unchanged and applies only the access check. When the block is disabled, requests pass straight through with no lookup, no walk and no check.

Top module: `lock_tlb`

## Requirements
- R1: After reset the block is idle (`req_ready` high, `resp_valid` and `walk_req_valid` low), every entry is empty and unlocked, and the replacement pointer is at entry 0.
- R2: When enabled and the request's page (address bits above the page offset) matches a held entry, `resp_valid` rises for one cycle, one cycle after acceptance. `resp_paddr` is the held physical page number joined to the untouched page offset, and no walk is issued.
- R3: On a miss, `walk_req_valid` rises the cycle after acceptance with `walk_req_addr` = table base + 4 × virtual page number. Both hold steady until `walk_req_ready`. `req_ready` stays low from acceptance until the response is given.
- R4: The response to a miss appears one cycle after `walk_rsp_valid` is taken. An entry whose bit 0 (valid) is set and whose bits above the page offset give the physical page is installed, so a later request to the same page hits.
- R5: A fetched entry with bit 0 clear gives `resp_xlat_fault`=1, `resp_paddr`=0 and `resp_perm_fault`=0, and installs nothing, so a repeat of the request walks again.
- R6: A user request (`req_user`=1) to a page whose bit 1 (user permitted) is clear gives `resp_perm_fault`=1. A supervisor request never does.
- R7: Refills go to the entry at the replacement pointer, searched upward with wraparound. After an install the pointer moves to the entry after the one filled.
- R8: A locked entry (`lock_we` with `lock_val`=1 at `lock_idx`) is skipped by the search, so its mapping keeps hitting while other pages are refilled. `lock_val`=0 unlocks it.
- R9: With every entry locked, a miss still completes with the fetched translation, but nothing is installed and the pointer does not move.
- R10: With `prot_only`=1 at acceptance, `resp_paddr` equals the request address. Lookup, walk and the user check behave as in translating mode.
- R11: With `en`=0 at acceptance, the response comes one cycle later with `resp_paddr` equal to the request address, both faults low and no walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables lookup and checking; low bypasses the block |
| prot_only | input | 1 | Check access rights only; address passes unchanged |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_vaddr | input | ADDR_W | Virtual address of the request |
| req_user | input | 1 | Request is made in user mode |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | ADDR_W | Physical address result |
| resp_perm_fault | output | 1 | User access to a supervisor-only page |
| resp_xlat_fault | output | 1 | Fetched table entry was not valid |
| walk_req_valid | output | 1 | Table read request |
| walk_req_ready | input | 1 | Table read request taken |
| walk_req_addr | output | ADDR_W | Address of the table word |
| walk_rsp_valid | input | 1 | Table word returned |
| walk_rsp_data | input | ADDR_W | Table word: page number above the offset, bit 1 user, bit 0 valid |
| lock_we | input | 1 | Write one lock bit |
| lock_idx | input | IDX_W | Entry whose lock bit is written |
| lock_val | input | 1 | New lock bit value |

## Verification
The bench builds the block with four entries, a 32-bit address, 4 KB pages and a table base of 0x0008_0000. Four entries make the pointer wrap after only four refills, and locking all of them to reach the no-install path takes just four lock writes. The walk responder stalls both the request handshake and the response by a varying number of cycles, which exercises the hold conditions of the walk port. Every cycle, the bench compares the handshake, walk and response ports against a behavioural model.

// File: rtl/tlbl_pkg.sv
package tlbl_pkg;

  // Walk sequencer states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WREQ = 2'd1,
    ST_WRSP = 2'd2
  } walk_st_e;

  // Bit positions inside a fetched page-table word
  localparam int PTE_V_BIT = 0;
  localparam int PTE_U_BIT = 1;

endpackage

// File: rtl/tlbl_cam.sv
module tlbl_cam #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_usr,
  input  logic             lock_we,
  input  logic [IDX_W-1:0] lock_idx,
  input  logic             lock_val,
  output logic [N-1:0]     match_vec,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  output logic             hit_usr,
  output logic [N-1:0]     lock_vec
);

  logic [PPN_W-1:0] ppn_w [N];
  logic             usr_w [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic             vld_q;
    logic             usr_q;
    logic             lck_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        usr_q <= 1'b0;
        lck_q <= 1'b0;
        vpn_q <= '0;
        ppn_q <= '0;
      end else begin
        if (wr_en && wr_idx == IDX_W'(g)) begin
          vld_q <= 1'b1;
          usr_q <= wr_usr;
          vpn_q <= wr_vpn;
          ppn_q <= wr_ppn;
        end
        if (lock_we && lock_idx == IDX_W'(g)) begin
          lck_q <= lock_val;
        end
      end
    end

    assign match_vec[g] = vld_q && (vpn_q == lk_vpn);
    assign lock_vec[g]  = lck_q;
    assign ppn_w[g]     = ppn_q;
    assign usr_w[g]     = usr_q;
  end

  // At most one entry matches, so an OR of the gated fields selects it
  always_comb begin
    hit_ppn = '0;
    hit_usr = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (match_vec[i]) begin
        hit_ppn = hit_ppn | ppn_w[i];
        hit_usr = hit_usr | usr_w[i];
      end
    end
  end

  assign hit = |match_vec;

endmodule

// File: rtl/tlbl_repl.sv
module tlbl_repl #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     lock_vec,
  input  logic             advance,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_ok
);

  logic [IDX_W-1:0] rr_q;

  function automatic logic [IDX_W-1:0] wrap_add(logic [IDX_W-1:0] base, int k);
    return IDX_W'((int'(base) + k) % N);
  endfunction

  // First unlocked entry at or after the pointer, with wraparound
  always_comb begin
    victim_ok  = 1'b0;
    victim_idx = rr_q;
    for (int k = N - 1; k >= 0; k--) begin
      if (!lock_vec[wrap_add(rr_q, k)]) begin
        victim_ok  = 1'b1;
        victim_idx = wrap_add(rr_q, k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (advance) begin
      rr_q <= wrap_add(victim_idx, 1);
    end
  end

endmodule

// File: rtl/lock_tlb.sv
module lock_tlb #(
  parameter int               NUM_ENT = 8,
  parameter int               ADDR_W  = 32,
  parameter int               PG_BITS = 12,
  parameter logic [ADDR_W-1:0] PT_BASE = 32'h0010_0000,
  localparam int              IDX_W   = $clog2(NUM_ENT),
  localparam int              VPN_W   = ADDR_W - PG_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              prot_only,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_user,
  output logic              resp_valid,
  output logic [ADDR_W-1:0] resp_paddr,
  output logic              resp_perm_fault,
  output logic              resp_xlat_fault,
  output logic              walk_req_valid,
  input  logic              walk_req_ready,
  output logic [ADDR_W-1:0] walk_req_addr,
  input  logic              walk_rsp_valid,
  input  logic [ADDR_W-1:0] walk_rsp_data,
  input  logic              lock_we,
  input  logic [IDX_W-1:0]  lock_idx,
  input  logic              lock_val
);
  import tlbl_pkg::*;

  localparam int PPN_W = VPN_W;

  // Address arithmetic kept in functions
  function automatic logic [ADDR_W-1:0] form_pa(logic prot, logic [PPN_W-1:0] ppn,
                                                logic [ADDR_W-1:0] va);
    return prot ? va : {ppn, va[PG_BITS-1:0]};
  endfunction

  function automatic logic perm_bad(logic user, logic allow);
    return user && !allow;
  endfunction

  function automatic logic [ADDR_W-1:0] pte_addr(logic [VPN_W-1:0] vpn);
    return PT_BASE + ADDR_W'({vpn, 2'b00});
  endfunction

  walk_st_e         st_q;
  logic [ADDR_W-1:0] va_q;
  logic              usr_q;
  logic              prot_q;

  // Named internal events
  logic              accept_w;
  logic              hit_w;
  logic              rsp_take_w;
  logic              pte_ok_w;
  logic              install_w;
  logic [N_SAFE()-1:0] match_vec;
  logic [NUM_ENT-1:0] lock_vec;
  logic [IDX_W-1:0]  victim_idx;
  logic              victim_ok;
  logic [PPN_W-1:0]  hit_ppn;
  logic              hit_usr;
  logic [PPN_W-1:0]  pte_ppn_w;
  logic              pte_usr_w;
  logic              unused_pte_bits;

  function automatic int N_SAFE();
    return NUM_ENT;
  endfunction

  assign req_ready      = (st_q == ST_IDLE);
  assign accept_w       = req_valid && req_ready;
  assign rsp_take_w     = (st_q == ST_WRSP) && walk_rsp_valid;
  assign pte_ok_w       = walk_rsp_data[PTE_V_BIT];
  assign pte_usr_w      = walk_rsp_data[PTE_U_BIT];
  assign pte_ppn_w      = walk_rsp_data[ADDR_W-1:PG_BITS];
  assign install_w      = rsp_take_w && pte_ok_w && victim_ok;
  assign walk_req_valid = (st_q == ST_WREQ);
  assign walk_req_addr  = pte_addr(va_q[ADDR_W-1:PG_BITS]);
  assign unused_pte_bits = ^walk_rsp_data[PG_BITS-1:2];

  tlbl_cam #(
    .N    (NUM_ENT),
    .VPN_W(VPN_W),
    .PPN_W(PPN_W),
    .IDX_W(IDX_W)
  ) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_vpn   (req_vaddr[ADDR_W-1:PG_BITS]),
    .wr_en    (install_w),
    .wr_idx   (victim_idx),
    .wr_vpn   (va_q[ADDR_W-1:PG_BITS]),
    .wr_ppn   (pte_ppn_w),
    .wr_usr   (pte_usr_w),
    .lock_we  (lock_we),
    .lock_idx (lock_idx),
    .lock_val (lock_val),
    .match_vec(match_vec),
    .hit      (hit_w),
    .hit_ppn  (hit_ppn),
    .hit_usr  (hit_usr),
    .lock_vec (lock_vec)
  );

  tlbl_repl #(
    .N    (NUM_ENT),
    .IDX_W(IDX_W)
  ) u_repl (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_vec  (lock_vec),
    .advance   (install_w),
    .victim_idx(victim_idx),
    .victim_ok (victim_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q            <= ST_IDLE;
      va_q            <= '0;
      usr_q           <= 1'b0;
      prot_q          <= 1'b0;
      resp_valid      <= 1'b0;
      resp_paddr      <= '0;
      resp_perm_fault <= 1'b0;
      resp_xlat_fault <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept_w) begin
            if (!en) begin
              resp_valid      <= 1'b1;
              resp_paddr      <= req_vaddr;
              resp_perm_fault <= 1'b0;
              resp_xlat_fault <= 1'b0;
            end else if (hit_w) begin
              resp_valid      <= 1'b1;
              resp_paddr      <= form_pa(prot_only, hit_ppn, req_vaddr);
              resp_perm_fault <= perm_bad(req_user, hit_usr);
              resp_xlat_fault <= 1'b0;
            end else begin
              st_q   <= ST_WREQ;
              va_q   <= req_vaddr;
              usr_q  <= req_user;
              prot_q <= prot_only;
            end
          end
        end
        ST_WREQ: begin
          if (walk_req_ready) st_q <= ST_WRSP;
        end
        ST_WRSP: begin
          if (walk_rsp_valid) begin
            st_q       <= ST_IDLE;
            resp_valid <= 1'b1;
            if (!pte_ok_w) begin
              resp_paddr      <= '0;
              resp_perm_fault <= 1'b0;
              resp_xlat_fault <= 1'b1;
            end else begin
              resp_paddr      <= form_pa(prot_q, pte_ppn_w, va_q);
              resp_perm_fault <= perm_bad(usr_q, pte_usr_w);
              resp_xlat_fault <= 1'b0;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lock_tlb_chk.sv
module lock_tlb_chk #(
  parameter int N      = 8,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              resp_valid,
  input logic [ADDR_W-1:0] resp_paddr,
  input logic              resp_perm_fault,
  input logic              resp_xlat_fault,
  input logic              walk_req_valid,
  input logic              walk_req_ready,
  input logic [ADDR_W-1:0] walk_req_addr,
  input logic              accept_w,
  input logic              hit_w,
  input logic              install_w,
  input logic [N-1:0]      match_vec,
  input logic [N-1:0]      lock_vec,
  input logic [IDX_W-1:0]  victim_idx
);

  p_hit_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && en && hit_w |=> resp_valid && !resp_xlat_fault);

  p_walk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid && !walk_req_ready |=> walk_req_valid && $stable(walk_req_addr));

  p_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid |-> !req_ready);

  p_single_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  p_fault_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !(resp_perm_fault && resp_xlat_fault));

  p_lock_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    install_w |-> !lock_vec[victim_idx]);

  p_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && !en |=> resp_valid && resp_paddr == $past(req_vaddr)
                        && !resp_perm_fault && !resp_xlat_fault);

endmodule

bind lock_tlb lock_tlb_chk #(
  .N     (NUM_ENT),
  .ADDR_W(ADDR_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .en             (en),
  .req_ready      (req_ready),
  .req_vaddr      (req_vaddr),
  .resp_valid     (resp_valid),
  .resp_paddr     (resp_paddr),
  .resp_perm_fault(resp_perm_fault),
  .resp_xlat_fault(resp_xlat_fault),
  .walk_req_valid (walk_req_valid),
  .walk_req_ready (walk_req_ready),
  .walk_req_addr  (walk_req_addr),
  .accept_w       (accept_w),
  .hit_w          (hit_w),
  .install_w      (install_w),
  .match_vec      (match_vec),
  .lock_vec       (lock_vec),
  .victim_idx     (victim_idx)
);

// File: tb/lock_tlb_tb.sv
module lock_tlb_tb;
  localparam int          N    = 4;
  localparam int          AW   = 32;
  localparam int          PGB  = 12;
  localparam logic [31:0] PTB  = 32'h0008_0000;
  localparam int          IW   = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic          en = 1'b0, prot_only = 1'b0, req_valid = 1'b0, req_user = 1'b0;
  logic [AW-1:0] req_vaddr = '0;
  logic          req_ready, resp_valid, resp_perm_fault, resp_xlat_fault;
  logic [AW-1:0] resp_paddr, walk_req_addr;
  logic          walk_req_valid;
  logic          walk_req_ready = 1'b0, walk_rsp_valid = 1'b0;
  logic [AW-1:0] walk_rsp_data = '0;
  logic          lock_we = 1'b0, lock_val = 1'b0;
  logic [IW-1:0] lock_idx = '0;

  lock_tlb #(.NUM_ENT(N), .ADDR_W(AW), .PG_BITS(PGB), .PT_BASE(PTB)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .prot_only(prot_only),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_user(req_user),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_perm_fault(resp_perm_fault), .resp_xlat_fault(resp_xlat_fault),
    .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready), .walk_req_addr(walk_req_addr),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_data(walk_rsp_data),
    .lock_we(lock_we), .lock_idx(lock_idx), .lock_val(lock_val));

  int    vectors = 0, miscompares = 0;
  bit    done = 0;
  string phase = "R1 reset";

  // Page table held by the bench; absent pages read as zero (invalid)
  logic [31:0] pt [int];

  // ---------------- behavioural reference model ----------------
  int          m_st = 0;             // 0 idle, 1 walk request, 2 walk response
  bit          m_vld [N];
  bit          m_lck [N];
  int          m_vpn [N];
  int          m_ppn [N];
  bit          m_usr [N];
  int          m_rr = 0;
  int          q_vpn = 0;
  logic [31:0] q_va = 0;
  bit          q_usr = 0, q_prot = 0;
  bit          e_rv = 0, e_pf = 0, e_tf = 0;
  logic [31:0] e_pa = 0;
  string       e_tag = "R2";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_rr = 0; e_rv = 0;
      for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_lck[i] = 0; end
    end else begin
      int vic;
      vic = -1;
      for (int k = 0; k < N; k++)
        if (vic < 0 && !m_lck[(m_rr + k) % N]) vic = (m_rr + k) % N;
      e_rv = 0;
      case (m_st)
        0: if (req_valid) begin
          int hi, vp;
          vp = int'(req_vaddr >> PGB);
          hi = -1;
          for (int i = 0; i < N; i++) if (m_vld[i] && m_vpn[i] == vp) hi = i;
          if (!en) begin
            e_rv = 1; e_pa = req_vaddr; e_pf = 0; e_tf = 0; e_tag = "R11";
          end else if (hi >= 0) begin
            e_rv = 1; e_tf = 0;
            e_pa = prot_only ? req_vaddr : ((m_ppn[hi] << PGB) | (req_vaddr & 32'hfff));
            e_pf = req_user && !m_usr[hi];
            e_tag = prot_only ? "R10" : (e_pf ? "R6" : "R2");
          end else begin
            m_st = 1; q_vpn = vp; q_va = req_vaddr; q_usr = req_user; q_prot = prot_only;
          end
        end
        1: if (walk_req_ready) m_st = 2;
        2: if (walk_rsp_valid) begin
          m_st = 0; e_rv = 1;
          if (!walk_rsp_data[0]) begin
            e_pa = 0; e_pf = 0; e_tf = 1; e_tag = "R5";
          end else begin
            e_tf = 0;
            e_pa = q_prot ? q_va : ((walk_rsp_data & 32'hffff_f000) | (q_va & 32'hfff));
            e_pf = q_usr && !walk_rsp_data[1];
            e_tag = q_prot ? "R10" : (e_pf ? "R6" : (vic < 0 ? "R9" : "R4"));
            if (vic >= 0) begin
              m_vld[vic] = 1; m_vpn[vic] = q_vpn; m_ppn[vic] = int'(walk_rsp_data >> PGB);
              m_usr[vic] = walk_rsp_data[1]; m_rr = (vic + 1) % N;
            end
          end
        end
        default: m_st = 0;
      endcase
      if (lock_we) m_lck[lock_idx] = lock_val;
    end
  end

  task automatic chk(string tag, string nm, logic [31:0] got, logic [31:0] exp);
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s [%s] %s: got %h expected %h", tag, phase, nm, got, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      chk("R3", "req_ready", 32'(req_ready), 32'(m_st == 0));
      chk("R3", "walk_req_valid", 32'(walk_req_valid), 32'(m_st == 1));
      if (m_st == 1) chk("R3", "walk_req_addr", walk_req_addr, PTB + 32'(q_vpn) * 4);
      chk(e_tag, "resp_valid", 32'(resp_valid), 32'(e_rv));
      if (e_rv) begin
        chk(e_tag, "resp_paddr", resp_paddr, e_pa);
        chk(e_tag, "resp_perm_fault", 32'(resp_perm_fault), 32'(e_pf));
        chk(e_tag, "resp_xlat_fault", 32'(resp_xlat_fault), 32'(e_tf));
      end
    end
  end

  // ---------------- walk port responder ----------------
  int rdy_delay = 0, rsp_delay = 0;
  int stall = 0, rs_cnt = 0, rs_vpn = 0;
  bit rs_busy = 0;
  always @(negedge clk) begin
    if (!rs_busy) begin
      walk_rsp_valid = 1'b0;
      if (walk_req_ready) begin
        walk_req_ready = 1'b0; rs_busy = 1; rs_cnt = rsp_delay;
      end else if (walk_req_valid) begin
        if (stall < rdy_delay) stall++;
        else begin
          stall = 0; walk_req_ready = 1'b1; rs_vpn = int'((walk_req_addr - PTB) >> 2);
        end
      end
    end else if (rs_cnt > 0) begin
      rs_cnt--;
    end else begin
      walk_rsp_valid = 1'b1;
      walk_rsp_data  = pt.exists(rs_vpn) ? pt[rs_vpn] : 32'h0;
      rs_busy = 0;
    end
  end

  // ---------------- stimulus ----------------
  task automatic xact(logic [31:0] va, bit usr, bit e, bit p);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_user = usr; en = e; prot_only = p;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic set_lock(int idx, bit v);
    @(negedge clk);
    lock_we = 1'b1; lock_idx = IW'(idx); lock_val = v;
    @(negedge clk);
    lock_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R3 [%s] watchdog: got busy expected idle", phase);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    pt[32'h10] = 32'hA0010_003;   // user page
    pt[32'h11] = 32'hB0011_001;   // supervisor-only page
    for (int v = 32'h12; v <= 32'h18; v++) pt[v] = ((32'hC0000 + v) << 12) | 32'h3;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs right after reset
    vectors++;
    if (req_ready !== 1'b1 || resp_valid !== 1'b0 || walk_req_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 [reset] ready/resp/walk: got %b%b%b expected 100",
               req_ready, resp_valid, walk_req_valid);
    end

    phase = "R11 bypass";   xact(32'h0001_1234, 1, 0, 0);
    phase = "R3 R4 refill"; xact(32'h0001_0abc, 1, 1, 0);
    phase = "R2 hit";       xact(32'h0001_0ffc, 1, 1, 0);
    rdy_delay = 2; rsp_delay = 3;
    phase = "R6 user fault"; xact(32'h0001_1010, 1, 1, 0);
    phase = "R6 supervisor"; xact(32'h0001_1020, 0, 1, 0);
    phase = "R5 invalid";    xact(32'h0002_0000, 0, 1, 0);
    phase = "R5 rewalk";     xact(32'h0002_0004, 0, 1, 0);
    rdy_delay = 0; rsp_delay = 1;
    phase = "R7 round-robin";
    xact(32'h0001_2000, 0, 1, 0);
    xact(32'h0001_3000, 0, 1, 0);
    xact(32'h0001_4000, 0, 1, 0);
    xact(32'h0001_0000, 1, 1, 0);
    xact(32'h0001_4008, 0, 1, 0);
    phase = "R8 lock";
    set_lock(2, 1); set_lock(3, 1);
    xact(32'h0001_5000, 0, 1, 0);
    xact(32'h0001_6000, 0, 1, 0);
    xact(32'h0001_7000, 0, 1, 0);
    xact(32'h0001_2abc, 0, 1, 0);
    xact(32'h0001_3abc, 1, 1, 0);
    phase = "R9 all locked";
    set_lock(0, 1); set_lock(1, 1);
    xact(32'h0001_8000, 1, 1, 0);
    xact(32'h0001_8004, 1, 1, 0);
    phase = "R8 unlock";
    for (int i = 0; i < N; i++) set_lock(i, 0);
    xact(32'h0001_8008, 1, 1, 0);
    phase = "R10 protect only";
    xact(32'h0001_2345, 1, 1, 1);
    xact(32'h0001_1678, 1, 1, 1);
    xact(32'h0001_1678, 0, 1, 1);
    phase = "R11 bypass late";
    xact(32'h0001_1999, 1, 0, 1);
    repeat (3) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule